// File: doc/BRIEF.md
# Emulated real-time-clock interrupt flag generator

This block produces the three classic real-time-clock interrupt causes from one programmable deadline timer. These causes are the seconds-rollover flag, the alarm-match flag and the periodic flag. The block does not contain the time-of-day counters. It watches their current hours, minutes and seconds values, which arrive as inputs, and it compares them against alarm registers that are also inputs. Timing comes from an externally supplied free-running reference count that advances at 2^REF_LOG2 counts per second. Inside, a compare register marks the next base tick. By default that tick is 64 per second, so one deadline spaced 2^(REF_LOG2-6) counts apart serves all three interrupt causes.

A periodic rate is requested as a power of two between 2 and 8192 per second. Rates up to 64 per second are made by dividing the base tick with a counter. Faster rates shorten the deadline spacing so that every tick carries a periodic flag. The reference count may jump past several deadlines between two samples. When that happens, the block advances its compare register beyond the reference in one step and adds the skipped ticks to the periodic divider. A burst of late ticks therefore still produces the right number of periodic events. On any tick that carries a cause, the block pulses a one-cycle interrupt strobe and presents a 16-bit flag word that holds the cause bits, a summary bit and an interrupt count.

Top module: `rtcf_gen`

## Requirements
- R1: While reset is held, and after it is released, `flags_o` is 0 and `irq_o` is low until a tick carries a cause.
- R2: In the cycle where the enable set goes from all-clear to non-empty, the deadline is armed at `ref_now_i` + D. D is 2^(REF_LOG2-6) unless the fast periodic mode of R4 is active. A tick happens in the first later cycle in which `ref_now_i` − deadline, read as a signed REF_W-bit value, is zero or positive. The outputs for that tick appear after the next clock edge.
- R3: On a tick with gap G = `ref_now_i` − deadline, L = floor(G / D) ticks are counted as lost. The new deadline is the old deadline + (L+1)·D, which is strictly ahead of `ref_now_i`.
- R4: With the periodic enable set and an effective rate code r above 6 (rate 2^r per second), D becomes 2^(REF_LOG2-r) and every tick raises the periodic flag.
- R5: With the periodic enable set and r at most 6, the divider count plus 1 plus L is compared on each tick against 2^(6-r). If the sum reaches the limit, the periodic flag is raised and the count returns to 0. Otherwise the count takes the sum.
- R6: With the update enable set, a tick raises the update flag when `sec_i` differs from the last recorded seconds value, and `sec_i` is then recorded. The recorded value is 0 after reset.
- R7: With the alarm enable set, a tick raises the alarm flag when hours, minutes and seconds all equal the alarm inputs.
- R8: Flag word: bit 4 update, bit 5 alarm, bit 6 periodic, bit 7 summary, bits 15:8 the count 1, bits 3:0 zero. When at least one cause is raised, `irq_o` is high for that one cycle and `flags_o` carries the word. In every other cycle, including ticks that raise no cause, `irq_o` is low and `flags_o` is 0.
- R9: While all three enables are clear the deadline timer is stopped and no strobe occurs. A later enable re-arms it as in R2.
- R10: A rate code of 0 acts as 1 (2 per second) and a code above 13 acts as 13 (8192 per second).
- R11: In any cycle with the periodic enable clear, the divider count is set to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| uie_i | input | 1 | Update (seconds change) interrupt enable |
| aie_i | input | 1 | Alarm interrupt enable |
| pie_i | input | 1 | Periodic interrupt enable |
| rate_sel_i | input | 4 | Periodic rate code r, rate = 2^r per second |
| ref_now_i | input | REF_W | Free-running reference count, 2^REF_LOG2 per second |
| hour_i | input | TIME_W | Current hours |
| min_i | input | TIME_W | Current minutes |
| sec_i | input | TIME_W | Current seconds |
| alm_hour_i | input | TIME_W | Alarm hours |
| alm_min_i | input | TIME_W | Alarm minutes |
| alm_sec_i | input | TIME_W | Alarm seconds |
| flags_o | output | 16 | Flag word, valid while `irq_o` is high |
| irq_o | output | 1 | One-cycle interrupt strobe |

## Verification
The assertions assume that, while the timer runs, the reference count moves forward by less than half of its 2^REF_W range between two clock edges. Only then does the signed gap comparison tell "reached" from "not yet reached". They also assume fewer than 2^LOST_W intervals are skipped in one step, so the lost-tick count does not saturate. The random stimulus chooses each step's advance from the active interval D. Most advances are at most one interval, and the occasional jump spans at most 30 intervals. Because D itself is at most 256 counts, both limits are kept. Rate codes, enables and time fields are left unconstrained, and alarm values are often forced equal to the current time so that matches occur.

// File: rtl/rtcf_pkg.sv
package rtcf_pkg;

    localparam int BASE_LOG2 = 6;
    localparam int RATE_MIN  = 1;
    localparam int RATE_MAX  = 13;

    localparam int BIT_UF   = 4;
    localparam int BIT_AF   = 5;
    localparam int BIT_PF   = 6;
    localparam int BIT_IRQF = 7;

    localparam logic [7:0] INT_COUNT = 8'd1;

    function automatic logic [3:0] clamp_rate(input logic [3:0] code);
        if (code < 4'(RATE_MIN)) begin
            return 4'(RATE_MIN);
        end else if (code > 4'(RATE_MAX)) begin
            return 4'(RATE_MAX);
        end
        return code;
    endfunction

endpackage

// File: rtl/rtcf_deadline.sv
module rtcf_deadline #(
    parameter int REF_W  = 16,
    parameter int SH_W   = 4,
    parameter int LOST_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic [SH_W-1:0]   dshift_i,
    input  logic [REF_W-1:0]  ref_now_i,
    output logic              fire_o,
    output logic [LOST_W-1:0] lost_o
);

    localparam logic [REF_W-1:0] LOST_MAX = REF_W'((1 << LOST_W) - 1);

    typedef struct packed {
        logic             run;
        logic [REF_W-1:0] cmp;
    } dl_state_t;

    dl_state_t st_d, st_q;

    logic [REF_W-1:0] delta;
    logic [REF_W-1:0] gap;
    logic [REF_W-1:0] whole;
    logic [REF_W-1:0] lost_full;

    always_comb begin
        delta     = REF_W'(1) << dshift_i;
        gap       = ref_now_i - st_q.cmp;
        whole     = gap & ~(delta - REF_W'(1));
        lost_full = gap >> dshift_i;
        fire_o    = st_q.run && en_i && !gap[REF_W-1];
        lost_o    = (lost_full > LOST_MAX) ? LOST_MAX[LOST_W-1:0] : lost_full[LOST_W-1:0];

        st_d = st_q;
        if (!en_i) begin
            st_d.run = 1'b0;
        end else if (!st_q.run) begin
            st_d.run = 1'b1;
            st_d.cmp = ref_now_i + delta;
        end else if (fire_o) begin
            st_d.cmp = st_q.cmp + whole + delta;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R3: after a tick the deadline lies strictly ahead of the count that caused it
    a_r3_deadline_ahead: assert property (@(posedge clk) disable iff (!rst_n)
        fire_o |=> ($signed($past(ref_now_i) - st_q.cmp) < 0));

    // R9: a cycle with every enable clear stops the timer for the next cycle
    a_r9_stopped_no_fire: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!en_i) |-> !fire_o);

endmodule

// File: rtl/rtcf_periodic.sv
module rtcf_periodic
    import rtcf_pkg::*;
#(
    parameter int LOST_W = 8,
    parameter int CNT_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire_i,
    input  logic              pie_i,
    input  logic [3:0]        rate_i,
    input  logic [LOST_W-1:0] lost_i,
    output logic              hit_o
);

    localparam int SUM_W = ((LOST_W > CNT_W) ? LOST_W : CNT_W) + 2;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } pd_state_t;

    pd_state_t st_d, st_q;

    logic [SUM_W-1:0] limit;
    logic [SUM_W-1:0] sum;

    always_comb begin
        if (rate_i > 4'(BASE_LOG2)) begin
            limit = SUM_W'(1);
        end else begin
            limit = SUM_W'(1) << (4'(BASE_LOG2) - rate_i);
        end
        sum   = SUM_W'(st_q.cnt) + SUM_W'(lost_i) + SUM_W'(1);
        hit_o = fire_i && pie_i && (sum >= limit);

        st_d = st_q;
        if (!pie_i) begin
            st_d.cnt = '0;
        end else if (fire_i) begin
            st_d.cnt = hit_o ? '0 : CNT_W'(sum);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R5: the divider count always stays below the largest limit
    a_r5_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        int'(st_q.cnt) < (1 << (BASE_LOG2 - 1)));

    // R11: periodic enable clear empties the divider
    a_r11_count_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!pie_i) |-> (st_q.cnt == '0));

endmodule

// File: rtl/rtcf_match.sv
module rtcf_match #(
    parameter int TIME_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire_i,
    input  logic              uie_i,
    input  logic              aie_i,
    input  logic [TIME_W-1:0] hour_i,
    input  logic [TIME_W-1:0] min_i,
    input  logic [TIME_W-1:0] sec_i,
    input  logic [TIME_W-1:0] alm_hour_i,
    input  logic [TIME_W-1:0] alm_min_i,
    input  logic [TIME_W-1:0] alm_sec_i,
    output logic              uf_o,
    output logic              af_o
);

    typedef struct packed {
        logic [TIME_W-1:0] last_sec;
    } mt_state_t;

    mt_state_t st_d, st_q;

    always_comb begin
        uf_o = fire_i && uie_i && (sec_i != st_q.last_sec);
        af_o = fire_i && aie_i && (hour_i == alm_hour_i)
                               && (min_i  == alm_min_i)
                               && (sec_i  == alm_sec_i);
        st_d = st_q;
        if (uf_o) begin
            st_d.last_sec = sec_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R6: an update flag records the seconds value it saw
    a_r6_sec_recorded: assert property (@(posedge clk) disable iff (!rst_n)
        uf_o |=> (st_q.last_sec == $past(sec_i)));

    // R6: without an update flag the recorded seconds stay put
    a_r6_sec_held: assert property (@(posedge clk) disable iff (!rst_n)
        !uf_o |=> $stable(st_q.last_sec));

endmodule

// File: rtl/rtcf_gen.sv
module rtcf_gen
    import rtcf_pkg::*;
#(
    parameter int REF_W    = 16,
    parameter int REF_LOG2 = 14,
    parameter int LOST_W   = 8,
    parameter int TIME_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              uie_i,
    input  logic              aie_i,
    input  logic              pie_i,
    input  logic [3:0]        rate_sel_i,
    input  logic [REF_W-1:0]  ref_now_i,
    input  logic [TIME_W-1:0] hour_i,
    input  logic [TIME_W-1:0] min_i,
    input  logic [TIME_W-1:0] sec_i,
    input  logic [TIME_W-1:0] alm_hour_i,
    input  logic [TIME_W-1:0] alm_min_i,
    input  logic [TIME_W-1:0] alm_sec_i,
    output logic [15:0]       flags_o,
    output logic              irq_o
);

    localparam int SH_W = $clog2(REF_LOG2 + 1);

    typedef struct packed {
        logic        irq;
        logic [15:0] word;
    } out_state_t;

    out_state_t st_d, st_q;

    logic              any_en;
    logic [3:0]        rate_eff;
    logic              fast;
    logic [SH_W-1:0]   dshift;
    logic              fire;
    logic [LOST_W-1:0] lost;
    logic              pf_hit;
    logic              uf_hit;
    logic              af_hit;

    always_comb begin
        any_en   = uie_i || aie_i || pie_i;
        rate_eff = clamp_rate(rate_sel_i);
        fast     = pie_i && (rate_eff > 4'(BASE_LOG2));
        if (fast) begin
            dshift = SH_W'(REF_LOG2 - int'(rate_eff));
        end else begin
            dshift = SH_W'(REF_LOG2 - BASE_LOG2);
        end
    end

    rtcf_deadline #(
        .REF_W  (REF_W),
        .SH_W   (SH_W),
        .LOST_W (LOST_W)
    ) u_deadline (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (any_en),
        .dshift_i  (dshift),
        .ref_now_i (ref_now_i),
        .fire_o    (fire),
        .lost_o    (lost)
    );

    rtcf_periodic #(
        .LOST_W (LOST_W),
        .CNT_W  (BASE_LOG2)
    ) u_periodic (
        .clk    (clk),
        .rst_n  (rst_n),
        .fire_i (fire),
        .pie_i  (pie_i),
        .rate_i (rate_eff),
        .lost_i (lost),
        .hit_o  (pf_hit)
    );

    rtcf_match #(
        .TIME_W (TIME_W)
    ) u_match (
        .clk        (clk),
        .rst_n      (rst_n),
        .fire_i     (fire),
        .uie_i      (uie_i),
        .aie_i      (aie_i),
        .hour_i     (hour_i),
        .min_i      (min_i),
        .sec_i      (sec_i),
        .alm_hour_i (alm_hour_i),
        .alm_min_i  (alm_min_i),
        .alm_sec_i  (alm_sec_i),
        .uf_o       (uf_hit),
        .af_o       (af_hit)
    );

    always_comb begin
        st_d = '0;
        if (uf_hit || af_hit || pf_hit) begin
            st_d.irq            = 1'b1;
            st_d.word[15:8]     = INT_COUNT;
            st_d.word[BIT_IRQF] = 1'b1;
            st_d.word[BIT_PF]   = pf_hit;
            st_d.word[BIT_AF]   = af_hit;
            st_d.word[BIT_UF]   = uf_hit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flags_o = st_q.word;
    assign irq_o   = st_q.irq;

    // R8: word is empty whenever the strobe is low
    a_r8_quiet_word: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_o |-> (flags_o == 16'h0000));

    // R8: a strobe carries the summary bit, count 1 and at least one cause
    a_r8_word_shape: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (flags_o[15:8] == 8'd1) && flags_o[BIT_IRQF]
                  && ($countones(flags_o[6:4]) > 0) && (flags_o[3:0] == 4'h0));

    // R9: no strobe after a cycle with every enable clear
    a_r9_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!(uie_i || aie_i || pie_i)) |-> !irq_o);

endmodule

// File: tb/rtcf_gen_bench.sv
module rtcf_gen_bench;

    localparam int REF_W    = 16;
    localparam int REF_LOG2 = 14;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        uie = 1'b0, aie = 1'b0, pie = 1'b0;
    logic [3:0]  rate = 4'd6;
    logic [15:0] ref_now = '0;
    logic [7:0]  hour = '0, mins = '0, sec = '0;
    logic [7:0]  a_hour = '0, a_min = '0, a_sec = '0;
    logic [15:0] flags;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // model state
    bit          m_run = 0;
    logic [15:0] m_cmp = '0;
    int          m_cnt = 0;
    logic [7:0]  m_prev = '0;
    bit          e_irq = 0;
    logic [15:0] e_word = '0;

    always #10 clk = ~clk;

    rtcf_gen #(.REF_W(REF_W), .REF_LOG2(REF_LOG2), .LOST_W(8), .TIME_W(8)) u_rtcf_gen (
        .clk(clk), .rst_n(rst_n), .uie_i(uie), .aie_i(aie), .pie_i(pie),
        .rate_sel_i(rate), .ref_now_i(ref_now), .hour_i(hour), .min_i(mins),
        .sec_i(sec), .alm_hour_i(a_hour), .alm_min_i(a_min), .alm_sec_i(a_sec),
        .flags_o(flags), .irq_o(irq)
    );

    function automatic int eff_rate(input logic [3:0] r);
        if (r == 0) return 1;
        if (r > 13) return 13;
        return int'(r);
    endfunction

    function automatic int delta_of(input bit p, input logic [3:0] r);
        int rs = eff_rate(r);
        if (p && rs > 6) return 1 << (REF_LOG2 - rs);
        return 1 << (REF_LOG2 - 6);
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic model_step();
        bit en = uie || aie || pie;
        int dl = delta_of(pie, rate);
        bit fire = 0;
        int lost = 0;
        bit uf = 0, af = 0, pf = 0;
        logic [15:0] g;
        e_irq = 0;
        e_word = '0;
        if (!en) begin
            m_run = 0;
        end else if (!m_run) begin
            m_run = 1;
            m_cmp = ref_now + 16'(dl);
        end else begin
            g = ref_now - m_cmp;
            if (!g[15]) begin
                fire = 1;
                lost = -1;
                do begin
                    m_cmp = m_cmp + 16'(dl);
                    lost++;
                    g = ref_now - m_cmp;
                end while (!g[15]);
            end
        end
        if (fire) begin
            uf = uie && (sec != m_prev);
            if (uf) m_prev = sec;
            af = aie && hour == a_hour && mins == a_min && sec == a_sec;
            if (pie) begin
                int rs = eff_rate(rate);
                int lim = (rs > 6) ? 1 : (1 << (6 - rs));
                m_cnt = m_cnt + 1 + lost;
                if (m_cnt >= lim) begin
                    pf = 1;
                    m_cnt = 0;
                end
            end
        end
        if (!pie) m_cnt = 0;
        if (uf || af || pf) begin
            e_irq = 1;
            e_word = {8'd1, 1'b1, pf, af, uf, 4'b0000};
        end
    endtask

    // inputs are set at a negedge; outputs are compared at the following negedge
    task automatic step();
        model_step();
        @(posedge clk);
        @(negedge clk);
        chk(irq == e_irq, "R8 strobe", {15'd0, irq}, {15'd0, e_irq});
        if (flags[6] != e_word[6])      chk(0, "R5 periodic flag", flags, e_word);
        else if (flags[5] != e_word[5]) chk(0, "R7 alarm flag", flags, e_word);
        else if (flags[4] != e_word[4]) chk(0, "R6 update flag", flags, e_word);
        else                            chk(flags == e_word, "R8 flag word", flags, e_word);
    endtask

    task automatic expect_word(input logic [15:0] exp, input string tag);
        chk(flags == exp && irq == (exp != 0), tag, flags, exp);
    endtask

    task automatic tick_now();
        ref_now = m_cmp;
        step();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk(flags == 0 && irq == 0, "R1 reset state", flags, 16'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(flags == 0 && irq == 0, "R1 after reset", flags, 16'h0);

        // R2 / R6: arm, early, exact deadline
        hour = 8'd3; mins = 8'd4; sec = 8'd5;
        uie = 1; ref_now = 16'd1000; step();
        ref_now = 16'd1255; step(); expect_word(16'h0000, "R2 before deadline");
        ref_now = 16'd1256; step(); expect_word(16'h0190, "R6 update on deadline");
        ref_now = 16'd1600; step(); expect_word(16'h0000, "R8 tick without cause");

        // R7 alarm
        a_hour = 8'd3; a_min = 8'd4; a_sec = 8'd5; aie = 1;
        ref_now = 16'd1768; step(); expect_word(16'h01A0, "R7 alarm match");
        sec = 8'd6;
        ref_now = 16'd2024; step(); expect_word(16'h0190, "R7 no match, R6 update");
        aie = 0;

        // R3 catch-up: deadline 2280, gap 3*256+10
        ref_now = 16'd3058; step();
        sec = 8'd7; ref_now = 16'd3303; step(); expect_word(16'h0000, "R3 not before new deadline");
        ref_now = 16'd3304; step(); expect_word(16'h0190, "R3 new deadline");

        // R5 divider, rate 16/s, limit 4, deadline 3560
        uie = 0; pie = 1; rate = 4'd4;
        ref_now = 16'd3560; step(); expect_word(16'h0000, "R5 tick 1");
        ref_now = 16'd3816; step(); expect_word(16'h0000, "R5 tick 2");
        ref_now = 16'd4072; step(); expect_word(16'h0000, "R5 tick 3");
        ref_now = 16'd4328; step(); expect_word(16'h01C0, "R5 fourth tick");
        ref_now = 16'd5096; step(); expect_word(16'h0000, "R5 lost two folded in");
        ref_now = 16'd5352; step(); expect_word(16'h01C0, "R5 catch-up periodic");

        // R4 fast rate 1024/s, interval 16
        rate = 4'd10;
        ref_now = 16'd5608; step(); expect_word(16'h01C0, "R4 fast tick");
        ref_now = 16'd5623; step(); expect_word(16'h0000, "R4 before short deadline");
        ref_now = 16'd5624; step(); expect_word(16'h01C0, "R4 short interval");

        // R10 clamps
        rate = 4'd15;
        ref_now = 16'd5640; step(); expect_word(16'h01C0, "R10 high clamp tick");
        ref_now = 16'd5641; step(); expect_word(16'h0000, "R10 high clamp early");
        ref_now = 16'd5642; step(); expect_word(16'h01C0, "R10 interval of two");
        rate = 4'd0;
        for (int i = 0; i < 31; i++) begin
            tick_now();
            if (irq) chk(0, "R10 low clamp early periodic", flags, 16'h0);
        end
        tick_now(); expect_word(16'h01C0, "R10 low clamp 32nd tick");

        // R11 clear of divider
        rate = 4'd4;
        tick_now(); tick_now();
        pie = 0; uie = 1; step();
        pie = 1; uie = 0;
        for (int i = 0; i < 3; i++) begin
            tick_now(); expect_word(16'h0000, "R11 divider restarted");
        end
        tick_now(); expect_word(16'h01C0, "R11 fourth tick after clear");

        // R9 stop and re-arm
        pie = 0;
        ref_now = m_cmp + 16'd5; step(); expect_word(16'h0000, "R9 stopped");
        ref_now = ref_now + 16'd600; step(); expect_word(16'h0000, "R9 still stopped");
        sec = 8'd9; uie = 1; ref_now = 16'd20000; step(); expect_word(16'h0000, "R9 arming cycle");
        ref_now = 16'd20255; step(); expect_word(16'h0000, "R9 before re-armed deadline");
        ref_now = 16'd20256; step(); expect_word(16'h0190, "R9 re-armed tick");

        // random phase
        for (int i = 0; i < 4000; i++) begin
            int dl;
            if ($urandom_range(0, 15) == 0) begin
                uie = 1'($urandom_range(0, 1));
                aie = 1'($urandom_range(0, 1));
                pie = 1'($urandom_range(0, 1));
            end
            if ($urandom_range(0, 31) == 0) rate = 4'($urandom_range(0, 15));
            if ($urandom_range(0, 3) == 0) sec = 8'($urandom_range(0, 3));
            hour = 8'($urandom_range(0, 1));
            mins = 8'($urandom_range(0, 1));
            if ($urandom_range(0, 1) == 0) begin
                a_hour = hour; a_min = mins; a_sec = sec;
            end else begin
                a_sec = 8'($urandom_range(0, 3));
            end
            dl = delta_of(pie, rate);
            if ($urandom_range(0, 19) == 0)
                ref_now = ref_now + 16'(dl * $urandom_range(1, 30));
            else
                ref_now = ref_now + 16'($urandom_range(0, dl));
            step();
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule